// File: doc/BRIEF.md
# Streaming 16-Point Radix-2 Delay-Feedback FFT

This block computes a 16-point forward discrete Fourier transform on a continuous stream of complex samples. Samples enter one per accepted clock in natural time order. Results leave one per clock in bit-reversed bin order. Every group of 16 accepted samples forms one frame. Frames may follow each other with no gap. Idle cycles may also be placed between samples; the pipeline then simply waits.

The datapath is a chain of four decimation-in-frequency radix-2 stages. Their feedback buffers hold 8, 4, 2 and 1 samples. A stage counts its own accepted samples. During the first half of its period it parks new samples in its buffer and sends out the older contents of that buffer. During the second half it adds the parked sample to the new one and sends out the sum. The difference goes back into the buffer, and the next half-period sends it on after a rotation by the stage's twiddle factor. Each stage halves its results with rounding, so the output is the DFT scaled by 1/16. Rotations by 1 or by -j use no multiplier. A general complex multiplier with saturation exists only in the two stages that need other factors.

The pipeline advances only on accepted samples. The last 15 samples' worth of a frame therefore stays in the buffers until later samples push it out. In practice, a frame's tail appears as the next frame is fed.

Top module: `r2sdf_fft16`

## Requirements
- R1: After reset `out_valid` is low. It stays low until 16 samples have been accepted. The first result comes from the 16th accepted sample.
- R2: For each frame, both components of every result are within 3 LSB of (1/16)·Σ x(n)·e^(−j2πkn/16). This holds for inputs of magnitude up to 12000 per component.
- R3: Result m of a frame (m = 0..15, counted from that frame's first result) carries bin k, where the 4-bit m is k with its bit order reversed (k = b3b2b1b0 gives m = b0b1b2b3). Frames come out in the order they were fed, 16 results each.
- R4: Once results have started, each accepted sample causes exactly one result, which appears on the ports 4 clocks after the sample is accepted. An idle input cycle causes no result.
- R5: Idle cycles between accepted samples do not change any result value.
- R6: Frames can be fed back to back. A frame's results depend only on that frame's own samples; an all-zero frame following non-zero frames gives exactly zero in every bin.
- R7: Rotation by −j is exact: (a + jb)·(−j) gives b − ja with no coefficient rounding. A frame whose samples are non-zero only at n = 0, 4, 8, 12 and are multiples of 16 therefore gives the exact integer DFT/16.
- R8: Each stage halves its sum and difference with round-half-up. A frame with every real part 32767 and every imaginary part −32768 gives exactly (32767, −32768) in bin 0 and exactly zero in all other bins, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample on `in_re`/`in_im` is accepted this clock |
| in_re | input | DW | Real part of input sample, two's complement |
| in_im | input | DW | Imaginary part of input sample, two's complement |
| out_valid | output | 1 | A result is present on `out_re`/`out_im` |
| out_re | output | DW | Real part of result, two's complement |
| out_im | output | DW | Imaginary part of result, two's complement |

## Verification
On every cycle, the in-RTL assertions check three things. First, no stage emits a result without an input in the cycle before. Second, every butterfly-phase input yields a result. Third, a stage's counter holds through idle cycles and nothing appears at the outputs before 16 samples have been accepted. Also checked every cycle: the multiplier turns a −j rotation into an exact swap and negation, and the last stage only ever sees the unit twiddle. Only the bench scenarios can show that the numbers are right. That covers the scaled DFT against a floating-point model, the bit-reversed placement of a single-bin tone, exactness for full-scale and quarter-period frames, the four-clock latency under stalls, and identical results for a stalled and an unstalled copy of the same frame.

// File: rtl/r2sdf_pkg.sv
package r2sdf_pkg;

  localparam int FFT_N   = 16;
  localparam int HALF_N  = FFT_N / 2;
  localparam int TW_KW   = $clog2(HALF_N);
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  // cos(2*pi*k/16) scaled by 2^TW_FRAC
  function automatic logic signed [TW_W-1:0] tw_cos(input logic [TW_KW-1:0] k);
    case (k)
      3'd0:    tw_cos = TW_W'(16384);
      3'd1:    tw_cos = TW_W'(15137);
      3'd2:    tw_cos = TW_W'(11585);
      3'd3:    tw_cos = TW_W'(6270);
      3'd4:    tw_cos = TW_W'(0);
      3'd5:    tw_cos = TW_W'(-6270);
      3'd6:    tw_cos = TW_W'(-11585);
      default: tw_cos = TW_W'(-15137);
    endcase
  endfunction

  // sin(2*pi*k/16) scaled by 2^TW_FRAC; the factor used is cos - j*sin
  function automatic logic signed [TW_W-1:0] tw_sin(input logic [TW_KW-1:0] k);
    case (k)
      3'd0:    tw_sin = TW_W'(0);
      3'd1:    tw_sin = TW_W'(6270);
      3'd2:    tw_sin = TW_W'(11585);
      3'd3:    tw_sin = TW_W'(15137);
      3'd4:    tw_sin = TW_W'(16384);
      3'd5:    tw_sin = TW_W'(15137);
      3'd6:    tw_sin = TW_W'(11585);
      default: tw_sin = TW_W'(6270);
    endcase
  endfunction

endpackage

// File: rtl/r2sdf_fbuf.sv
module r2sdf_fbuf #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (en) begin
      mem_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) mem_q[i] <= mem_q[i-1];
    end
  end

  assign dout = mem_q[DEPTH-1];

endmodule

// File: rtl/r2sdf_stage.sv
module r2sdf_stage
  import r2sdf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic [TW_KW-1:0]     out_k
);

  localparam int CW    = $clog2(2 * DEPTH);
  localparam int KSTEP = HALF_N / DEPTH;

  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 primed_q, primed_d;
  logic                 phase;
  logic signed [DW-1:0] hd_re, hd_im, wr_re, wr_im;
  logic signed [DW:0]   sum_re, sum_im, dif_re, dif_im;
  logic [CW-1:0]        n_pos;
  logic [TW_KW-1:0]     k_pos, k_d;
  logic                 vld_d;
  logic signed [DW-1:0] re_d, im_d;

  r2sdf_fbuf #(.W(2 * DW), .DEPTH(DEPTH)) u_fbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_vld),
    .din  ({wr_re, wr_im}),
    .dout ({hd_re, hd_im})
  );

  assign phase = cnt_q[CW-1];

  // butterfly arithmetic, halved with round-half-up
  always_comb begin
    sum_re = {hd_re[DW-1], hd_re} + {in_re[DW-1], in_re} + (DW+1)'(1);
    sum_im = {hd_im[DW-1], hd_im} + {in_im[DW-1], in_im} + (DW+1)'(1);
    dif_re = {hd_re[DW-1], hd_re} - {in_re[DW-1], in_re} + (DW+1)'(1);
    dif_im = {hd_im[DW-1], hd_im} - {in_im[DW-1], in_im} + (DW+1)'(1);
  end

  // next state
  always_comb begin
    n_pos    = cnt_q & CW'(DEPTH - 1);
    k_pos    = TW_KW'(n_pos * KSTEP);
    cnt_d    = in_vld ? cnt_q + CW'(1) : cnt_q;
    primed_d = primed_q | (in_vld & phase);
    vld_d    = in_vld & (phase | primed_q);
    if (phase) begin
      wr_re = dif_re[DW:1];
      wr_im = dif_im[DW:1];
      re_d  = sum_re[DW:1];
      im_d  = sum_im[DW:1];
      k_d   = '0;
    end else begin
      wr_re = in_re;
      wr_im = in_im;
      re_d  = hd_re;
      im_d  = hd_im;
      k_d   = k_pos;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      out_vld  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_re <= '0;
      out_im <= '0;
      out_k  <= '0;
    end else if (in_vld) begin
      out_re <= re_d;
      out_im <= im_d;
      out_k  <= k_d;
    end
  end

  // R4
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R4
  bfly_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && phase) |=> out_vld);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(cnt_q));

endmodule

// File: rtl/r2sdf_twiddle.sv
module r2sdf_twiddle
  import r2sdf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [TW_KW-1:0]     in_k,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  assign out_vld = in_vld;

  generate
    if (DEPTH == 1) begin : g_unit
      assign out_re = in_re;
      assign out_im = in_im;

      // R7
      unit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (in_k == '0));

    end else if (DEPTH == 2) begin : g_negj
      logic signed [DW-1:0] neg_re;
      assign neg_re = (in_re == MINV) ? MAXV : -in_re;
      assign out_re = (in_k == '0) ? in_re : in_im;
      assign out_im = (in_k == '0) ? in_im : neg_re;

    end else begin : g_cmul
      localparam int PW = DW + TW_W + 1;
      localparam logic signed [PW-1:0] MAXP = PW'(MAXV);
      localparam logic signed [PW-1:0] MINP = PW'(MINV);
      localparam logic signed [PW-1:0] HALF = PW'(1) <<< (TW_FRAC - 1);

      function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
        if (v > MAXP)      sat = MAXV;
        else if (v < MINP) sat = MINV;
        else               sat = v[DW-1:0];
      endfunction

      logic signed [TW_W-1:0] c_co, c_si;
      logic signed [PW-1:0]   p_re, p_im, r_re, r_im;

      always_comb begin
        c_co = tw_cos(in_k);
        c_si = tw_sin(in_k);
        p_re = PW'(in_re) * PW'(c_co) + PW'(in_im) * PW'(c_si);
        p_im = PW'(in_im) * PW'(c_co) - PW'(in_re) * PW'(c_si);
        r_re = (p_re + HALF) >>> TW_FRAC;
        r_im = (p_im + HALF) >>> TW_FRAC;
      end

      // unit factor bypasses the multiplier
      assign out_re = (in_k == '0) ? in_re : sat(r_re);
      assign out_im = (in_k == '0) ? in_im : sat(r_im);

      // R7
      negj_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_k == TW_KW'(HALF_N / 2) && in_re != MINV)
          |-> (out_re == in_im && out_im == -in_re));
    end
  endgenerate

endmodule

// File: rtl/r2sdf_fft16.sv
module r2sdf_fft16
  import r2sdf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int STAGES = $clog2(FFT_N);
  localparam int ACC_W  = $clog2(FFT_N + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic                 x_vld [STAGES+1];
  logic signed [DW-1:0] x_re  [STAGES+1];
  logic signed [DW-1:0] x_im  [STAGES+1];
  logic                 y_vld [STAGES];
  logic signed [DW-1:0] y_re  [STAGES];
  logic signed [DW-1:0] y_im  [STAGES];
  logic [TW_KW-1:0]     y_k   [STAGES];

  assign x_vld[0] = in_valid;
  assign x_re[0]  = in_re;
  assign x_im[0]  = in_im;

  for (genvar s = 0; s < STAGES; s++) begin : g_pipe
    localparam int D = HALF_N >> s;

    r2sdf_stage #(.DW(DW), .DEPTH(D)) u_stage (
      .clk    (clk),
      .rst_n  (rst_ni),
      .in_vld (x_vld[s]),
      .in_re  (x_re[s]),
      .in_im  (x_im[s]),
      .out_vld(y_vld[s]),
      .out_re (y_re[s]),
      .out_im (y_im[s]),
      .out_k  (y_k[s])
    );

    r2sdf_twiddle #(.DW(DW), .DEPTH(D)) u_twid (
      .clk    (clk),
      .rst_n  (rst_ni),
      .in_vld (y_vld[s]),
      .in_re  (y_re[s]),
      .in_im  (y_im[s]),
      .in_k   (y_k[s]),
      .out_vld(x_vld[s+1]),
      .out_re (x_re[s+1]),
      .out_im (x_im[s+1])
    );
  end

  assign out_valid = x_vld[STAGES];
  assign out_re    = x_re[STAGES];
  assign out_im    = x_im[STAGES];

  // accepted-sample count, saturating, for the start-up check
  logic [ACC_W-1:0] acc_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                                  acc_q <= '0;
    else if (in_valid && acc_q != ACC_W'(FFT_N))  acc_q <= acc_q + ACC_W'(1);
  end

  // R1
  first_out_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (acc_q == ACC_W'(FFT_N)));

endmodule

// File: tb/r2sdf_fft16_bench.sv
module r2sdf_fft16_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  DW         = 16;
  localparam real PI         = 3.14159265358979;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_re, out_im;

  r2sdf_fft16 #(.DW(DW)) u_r2sdf_fft16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, ocount = 0, icount = 0, nfr = 0;
  bit done = 1'b0;
  int xr [32][16];
  int xi [32][16];
  int o_re [512];
  int o_im [512];
  int o_cyc [512];
  int i_cyc [512];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && ocount < 512) begin
      o_re[ocount]  = int'(out_re);
      o_im[ocount]  = int'(out_im);
      o_cyc[ocount] = cyc;
      ocount++;
    end
    if (rst_n && in_valid && icount < 512) begin
      i_cyc[icount] = cyc;
      icount++;
    end
  end

  task automatic report(input bit ok, input string req, input string what,
                        input string act, input string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  function automatic int bitrev4(input int k);
    return ((k & 1) << 3) | ((k & 2) << 1) | ((k & 4) >> 1) | ((k & 8) >> 3);
  endfunction

  task automatic send_sample(input int re, input int im);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_re    = DW'(re);
    in_im    = DW'(im);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic send_frame(input int f, input int gap);
    for (int n = 0; n < 16; n++) begin
      send_sample(xr[f][n], xi[f][n]);
      if (gap > 0) idle(gap);
    end
  endtask

  function automatic int new_zero_frame();
    int f = nfr;
    for (int n = 0; n < 16; n++) begin
      xr[f][n] = 0;
      xi[f][n] = 0;
    end
    nfr++;
    return f;
  endfunction

  // compare frame f against the scaled DFT computed here in floating point
  task automatic check_frame(input int f, input real tol, input string req);
    if (ocount < (f + 1) * 16) begin
      report(1'b0, req, $sformatf("frame %0d result count", f),
             $sformatf("%0d", ocount), $sformatf(">=%0d", (f + 1) * 16));
      return;
    end
    for (int k = 0; k < 16; k++) begin
      real er = 0.0, ei = 0.0;
      int  idx = f * 16 + bitrev4(k);
      for (int n = 0; n < 16; n++) begin
        real a = -2.0 * PI * real'(k * n) / 16.0;
        er += real'(xr[f][n]) * $cos(a) - real'(xi[f][n]) * $sin(a);
        ei += real'(xr[f][n]) * $sin(a) + real'(xi[f][n]) * $cos(a);
      end
      er = er / 16.0;
      ei = ei / 16.0;
      report((o_re[idx] - er <= tol + 0.001) && (er - o_re[idx] <= tol + 0.001) &&
             (o_im[idx] - ei <= tol + 0.001) && (ei - o_im[idx] <= tol + 0.001),
             req, $sformatf("frame %0d bin %0d", f, k),
             $sformatf("(%0d,%0d)", o_re[idx], o_im[idx]),
             $sformatf("(%0.2f,%0.2f)", er, ei));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: quiet after reset
    report(out_valid == 1'b0, "R1", "out_valid after reset",
           $sformatf("%0b", out_valid), "0");
  endtask

  task automatic t_impulse();
    int f = new_zero_frame();
    int z;
    xr[f][0] = 8000;
    xi[f][0] = -4000;
    for (int n = 0; n < 15; n++) send_sample(xr[f][n], xi[f][n]);
    idle(8);
    // R1: nothing before the 16th sample
    report(ocount == 0, "R1", "results after 15 samples",
           $sformatf("%0d", ocount), "0");
    send_sample(xr[f][15], xi[f][15]);
    idle(6);
    report(ocount == 1, "R1", "results after 16 samples",
           $sformatf("%0d", ocount), "1");
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    check_frame(f, 3.0, "R2");
  endtask

  task automatic t_dc_full();
    int f = nfr;
    int z;
    nfr++;
    for (int n = 0; n < 16; n++) begin
      xr[f][n] = 32767;
      xi[f][n] = -32768;
    end
    send_frame(f, 0);
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    // R8: exact, no wrap
    check_frame(f, 0.0, "R8");
  endtask

  task automatic t_quarter();
    int f = new_zero_frame();
    int z;
    xr[f][0]  = 1600;  xi[f][0]  = 0;
    xr[f][4]  = 0;     xi[f][4]  = 3200;
    xr[f][8]  = -800;  xi[f][8]  = 0;
    xr[f][12] = 480;   xi[f][12] = -960;
    send_frame(f, 0);
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    // R7: only unit and -j rotations involved, result exact
    check_frame(f, 0.0, "R7");
  endtask

  task automatic t_tone();
    int f = new_zero_frame();
    int z, big;
    for (int n = 0; n < 16; n++) begin
      real a = 2.0 * PI * real'(5 * n) / 16.0;
      xr[f][n] = $rtoi(4000.0 * $cos(a));
      xi[f][n] = $rtoi(4000.0 * $sin(a));
    end
    send_frame(f, 0);
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    // R3: bin 5 must land at position 10 of the frame
    big = -1;
    for (int m = 0; m < 16; m++) begin
      int idx = f * 16 + m;
      if (o_re[idx] > 1000 || o_re[idx] < -1000 || o_im[idx] > 1000 || o_im[idx] < -1000)
        big = (big == -1) ? m : 99;
    end
    report(big == 10, "R3", "position of bin 5 tone",
           $sformatf("%0d", big), "10");
    check_frame(f, 3.0, "R2");
  endtask

  int lcg = 32'h1234_5678;

  function automatic int next_val();
    lcg = lcg * 1103515245 + 12345;
    return int'((32'(lcg) >> 8) % 24001) - 12000;
  endfunction

  int mixed_a = 0;

  task automatic t_mixed_b2b();
    int fa = new_zero_frame();
    int fb = new_zero_frame();
    int z;
    mixed_a = fa;
    for (int n = 0; n < 16; n++) begin
      xr[fa][n] = next_val(); xi[fa][n] = next_val();
      xr[fb][n] = next_val(); xi[fb][n] = next_val();
    end
    send_frame(fa, 0);
    send_frame(fb, 0);
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    // R6: consecutive frames without gap
    check_frame(fa, 3.0, "R6");
    check_frame(fb, 3.0, "R6");
  endtask

  task automatic t_stall();
    int fs = new_zero_frame();
    int z, zprev, mism;
    zprev = fs - 1;
    for (int n = 0; n < 16; n++) begin
      xr[fs][n] = xr[mixed_a][n];
      xi[fs][n] = xi[mixed_a][n];
    end
    send_frame(fs, 2);
    z = new_zero_frame();
    send_frame(z, 0);
    idle(10);
    // R6: zero frame after non-zero frames is exactly zero
    check_frame(zprev, 0.0, "R6");
    check_frame(fs, 3.0, "R5");
    mism = 0;
    for (int m = 0; m < 16; m++)
      if (o_re[fs*16+m] != o_re[mixed_a*16+m] || o_im[fs*16+m] != o_im[mixed_a*16+m])
        mism++;
    // R5: stalled copy matches unstalled frame bit for bit
    report(mism == 0, "R5", "stalled vs unstalled mismatches",
           $sformatf("%0d", mism), "0");
  endtask

  task automatic t_latency();
    int bad = -1;
    for (int j = 0; j < ocount; j++)
      if (j + 15 < icount && bad == -1 && o_cyc[j] != i_cyc[j + 15] + 4) bad = j;
    // R4: each result 4 clocks after its sample, also under stalls
    report(bad == -1, "R4", "first result with wrong latency",
           $sformatf("%0d", bad), "-1");
    report(ocount == icount - 15, "R4", "result count vs accepted samples",
           $sformatf("%0d", ocount), $sformatf("%0d", icount - 15));
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_dc_full();
    t_quarter();
    t_tone();
    t_mixed_b2b();
    t_stall();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule